// File: doc/BRIEF.md
# Missing-Memory Machine-Check Sequencer

This block sits behind the address translation stage. It watches each translated physical address against the amount of memory installed. When a valid address lands at or beyond that limit, the block takes over. It records the machine state in three fixed diagnostic slots of the register file, one slot per cycle. It then decides how the check is entered, based on the process-exchange enable bit of the modes word.

**Process exchange disabled.** The sequencer enters the check as a jump-and-store-return through a vector held in memory. It reads the vector word, writes the faulting program counter to the word the vector points at, and loads that pointer plus one as the new program counter. A one-cycle restart pulse to the fetch logic accompanies the new program counter.

**Process exchange enabled.** The block stops after logging. It raises a one-cycle flag so that external logic can run the exchange-based check protocol.

While a check is in progress, further out-of-range addresses are ignored.

Top module: `mmchk_seq`

## Requirements
- R1: A check starts only when `chk_valid` is high and `chk_paddr` is greater than or equal to `mem_limit`, compared as unsigned numbers. A valid address below the limit causes no register write, no memory access, no restart and no `px_check`.
- R2: A check writes the register file in three consecutive cycles, in this order:
  - slot octal 36 receives the program counter, zero-extended;
  - slot octal 35 receives the status word 0xD000;
  - slot octal 34 receives the faulting physical address, zero-extended.
- R3: Process exchange is enabled when bit 3 of `modes` (value octal 010) is set. With it enabled, the three writes are followed by a one-cycle `px_check` pulse, with no memory access and no restart.
- R4: With process exchange disabled, the first memory access is a read of word address octal 071. The word read back is the target.
- R5: The second memory access writes the captured program counter to the target address.
- R6: The block then presents `new_pc` equal to the target plus one, modulo 2^PC_W, together with a `restart` pulse lasting exactly one cycle. Exactly one restart occurs per check.
- R7: Each memory access keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until `mem_ready` is sampled high. The sequence completes for any number of wait cycles.
- R8: A qualifying address presented while a check is pending or in progress is ignored. Its address and program counter are never logged, and it causes no extra restart.
- R9: After reset, `busy`, `restart`, `px_check`, `rf_we` and `mem_req` are all low.
- R10: `busy` is high in the cycle after a qualifying address is accepted. It is low again once the restart or `px_check` pulse has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | Translated address valid |
| chk_paddr | input | PA_W | Translated physical address |
| mem_limit | input | PA_W | First address beyond installed memory |
| cur_pc | input | PC_W | Program counter of the faulting access |
| modes | input | MODE_W | Modes word; bit 3 enables process exchange |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | RF_AW | Register-file slot |
| rf_wdata | output | RF_DW | Register-file write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | PC_W | Memory word address |
| mem_wdata | output | PC_W | Memory write data |
| mem_rdata | input | PC_W | Memory read data, valid with ready |
| mem_ready | input | 1 | Access complete |
| new_pc | output | PC_W | Program counter to resume at |
| restart | output | 1 | One-cycle pulse: fetch from new_pc |
| px_check | output | 1 | One-cycle pulse: exchange-based check required |
| busy | output | 1 | Check pending or in progress |

## Verification
The assertions assume that `mem_ready` comes only in answer to a pending `mem_req`, and that the read data is valid in the same cycle as ready. They also assume that `modes` stays still while a check is being accepted. The bench memory model raises ready only for an outstanding request, after a programmable wait of zero to two cycles. It then drops ready in the following cycle, so every access meets these assumptions.

The stimulus sweeps addresses from two below to two above several limits, including the top of the address space. Each address is run with both settings of the exchange bit and every wait length. A second qualifying address is presented only while a check is already in progress.

// File: rtl/mmchk_pkg.sv
package mmchk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOG,
    ST_VREAD,
    ST_RSTORE,
    ST_JUMP
  } seq_state_t;

  // fixed diagnostic slots, in the order they are written
  localparam logic [5:0]  SLOT_PC    = 6'o36;
  localparam logic [5:0]  SLOT_STAT  = 6'o35;
  localparam logic [5:0]  SLOT_ADDR  = 6'o34;
  localparam int          N_SLOTS    = 3;
  localparam logic [15:0] MISS_STAT  = 16'hD000;
  localparam int          VEC_DIRECT = 'o71;
  localparam int          PX_BIT     = 3;
endpackage

// File: rtl/mmchk_detect.sv
module mmchk_detect #(
  parameter int PA_W = 24,
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            chk_valid,
  input  logic [PA_W-1:0] chk_paddr,
  input  logic [PA_W-1:0] mem_limit,
  input  logic [PC_W-1:0] cur_pc,
  input  logic            px_en,
  input  logic            seq_busy,
  output logic            start,
  output logic [PA_W-1:0] cap_paddr,
  output logic [PC_W-1:0] cap_pc,
  output logic            cap_px
);
  logic hit;
  assign hit = chk_valid && (chk_paddr >= mem_limit) && !seq_busy && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      start     <= 1'b0;
      cap_paddr <= '0;
      cap_pc    <= '0;
      cap_px    <= 1'b0;
    end else begin
      start <= hit;
      if (hit) begin
        cap_paddr <= chk_paddr;
        cap_pc    <= cur_pc;
        cap_px    <= px_en;
      end
    end
  end

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (seq_busy || start) |=> ($stable(cap_paddr) && $stable(cap_pc) && $stable(cap_px))); // R8

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    start |=> !start); // R10
endmodule

// File: rtl/mmchk_fsm.sv
module mmchk_fsm
  import mmchk_pkg::*;
#(
  parameter int PA_W  = 24,
  parameter int PC_W  = 16,
  parameter int RF_AW = 6,
  parameter int RF_DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PA_W-1:0]  cap_paddr,
  input  logic [PC_W-1:0]  cap_pc,
  input  logic             cap_px,
  output logic             seq_busy,
  output logic             rf_we,
  output logic [RF_AW-1:0] rf_addr,
  output logic [RF_DW-1:0] rf_wdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PC_W-1:0]  mem_addr,
  output logic [PC_W-1:0]  mem_wdata,
  input  logic [PC_W-1:0]  mem_rdata,
  input  logic             mem_ready,
  output logic [PC_W-1:0]  new_pc,
  output logic             restart,
  output logic             px_check
);
  localparam int              IDX_W    = $clog2(N_SLOTS);
  localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(N_SLOTS - 1);
  localparam logic [PC_W-1:0] VEC_ADDR = PC_W'(VEC_DIRECT);

  seq_state_t       state_q;
  logic [IDX_W-1:0] log_ix;
  logic [PC_W-1:0]  tgt_q;
  logic [PC_W-1:0]  new_pc_q;
  logic             px_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      log_ix   <= '0;
      tgt_q    <= '0;
      new_pc_q <= '0;
      px_q     <= 1'b0;
    end else begin
      px_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_LOG;
          log_ix  <= '0;
        end
        ST_LOG: begin
          if (log_ix == LAST_IX) begin
            log_ix <= '0;
            if (cap_px) begin
              state_q <= ST_IDLE;
              px_q    <= 1'b1;
            end else begin
              state_q <= ST_VREAD;
            end
          end else begin
            log_ix <= log_ix + 1'b1;
          end
        end
        ST_VREAD: if (mem_ready) begin
          tgt_q   <= mem_rdata;
          state_q <= ST_RSTORE;
        end
        ST_RSTORE: if (mem_ready) begin
          new_pc_q <= tgt_q + 1'b1;
          state_q  <= ST_JUMP;
        end
        ST_JUMP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // outputs decoded from registered state only
  always_comb begin
    rf_we = (state_q == ST_LOG);
    case (log_ix)
      IDX_W'(0): begin
        rf_addr  = RF_AW'(SLOT_PC);
        rf_wdata = RF_DW'(cap_pc);
      end
      IDX_W'(1): begin
        rf_addr  = RF_AW'(SLOT_STAT);
        rf_wdata = RF_DW'(MISS_STAT);
      end
      default: begin
        rf_addr  = RF_AW'(SLOT_ADDR);
        rf_wdata = RF_DW'(cap_paddr);
      end
    endcase
  end

  assign mem_req   = (state_q == ST_VREAD) || (state_q == ST_RSTORE);
  assign mem_we    = (state_q == ST_RSTORE);
  assign mem_addr  = (state_q == ST_RSTORE) ? tgt_q : VEC_ADDR;
  assign mem_wdata = cap_pc;
  assign restart   = (state_q == ST_JUMP);
  assign new_pc    = new_pc_q;
  assign px_check  = px_q;
  assign seq_busy  = (state_q != ST_IDLE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R7

  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (rst)
    restart |=> !restart); // R6

  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({restart, px_check, rf_we})); // R3

  AST_PX_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    (cap_px && seq_busy) |-> !mem_req); // R3

  AST_LOG_THEN_MEM: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> ($past(rf_we) && !mem_we)); // R4
endmodule

// File: rtl/mmchk_seq.sv
module mmchk_seq
  import mmchk_pkg::*;
#(
  parameter int PA_W   = 24,
  parameter int PC_W   = 16,
  parameter int MODE_W = 16,
  parameter int RF_AW  = 6,
  parameter int RF_DW  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_valid,
  input  logic [PA_W-1:0]   chk_paddr,
  input  logic [PA_W-1:0]   mem_limit,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [MODE_W-1:0] modes,
  output logic              rf_we,
  output logic [RF_AW-1:0]  rf_addr,
  output logic [RF_DW-1:0]  rf_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PC_W-1:0]   mem_addr,
  output logic [PC_W-1:0]   mem_wdata,
  input  logic [PC_W-1:0]   mem_rdata,
  input  logic              mem_ready,
  output logic [PC_W-1:0]   new_pc,
  output logic              restart,
  output logic              px_check,
  output logic              busy
);
  logic            start;
  logic            seq_busy;
  logic [PA_W-1:0] cap_paddr;
  logic [PC_W-1:0] cap_pc;
  logic            cap_px;

  mmchk_detect #(.PA_W(PA_W), .PC_W(PC_W)) u_detect (
    .clk(clk), .rst(rst),
    .chk_valid(chk_valid), .chk_paddr(chk_paddr), .mem_limit(mem_limit),
    .cur_pc(cur_pc), .px_en(modes[PX_BIT]), .seq_busy(seq_busy),
    .start(start), .cap_paddr(cap_paddr), .cap_pc(cap_pc), .cap_px(cap_px)
  );

  mmchk_fsm #(.PA_W(PA_W), .PC_W(PC_W), .RF_AW(RF_AW), .RF_DW(RF_DW)) u_fsm (
    .clk(clk), .rst(rst),
    .start(start), .cap_paddr(cap_paddr), .cap_pc(cap_pc), .cap_px(cap_px),
    .seq_busy(seq_busy),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .new_pc(new_pc), .restart(restart), .px_check(px_check)
  );

  assign busy = start || seq_busy;

  AST_BUSY_DONE: assert property (@(posedge clk) disable iff (rst)
    (restart || px_check) |=> !seq_busy || start); // R10
endmodule

// File: tb/tb_mmchk_seq.sv
module tb_mmchk_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chk_valid = 1'b0;
  logic [23:0] chk_paddr = '0;
  logic [23:0] mem_limit = '0;
  logic [15:0] cur_pc = '0;
  logic [15:0] modes = '0;
  logic        rf_we;
  logic [5:0]  rf_addr;
  logic [31:0] rf_wdata;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic [15:0] new_pc;
  logic        restart, px_check, busy;

  mmchk_seq dut (
    .clk(clk), .rst(rst), .chk_valid(chk_valid), .chk_paddr(chk_paddr),
    .mem_limit(mem_limit), .cur_pc(cur_pc), .modes(modes),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .new_pc(new_pc), .restart(restart), .px_check(px_check), .busy(busy)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int lat = 0;
  int wcnt = 0;
  int n_acc = 0;
  int n_rf = 0;
  int n_rst = 0;
  int n_px = 0;
  logic [15:0] last_pc = '0;
  logic [5:0]  log_a [0:7];
  logic [31:0] log_d [0:7];
  logic [15:0] bmem [0:65535];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor and memory model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (rf_we) begin
      if (n_rf < 8) begin
        log_a[n_rf] = rf_addr;
        log_d[n_rf] = rf_wdata;
      end
      n_rf++;
    end
    if (restart) begin
      n_rst++;
      last_pc = new_pc;
    end
    if (px_check) n_px++;
    if (mem_ready) begin
      mem_ready = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ready = 1'b1;
        mem_rdata = bmem[mem_addr];
        if (mem_we) bmem[mem_addr] = mem_wdata;
        n_acc++;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic run_case(input logic [23:0] pa, input logic [23:0] lim, input logic [15:0] pc,
                          input bit px, input logic [15:0] tgt);
    bit hit;
    hit = (pa >= lim);
    bmem[16'o71] = tgt;
    bmem[tgt] = 16'h0000;
    n_acc = 0; n_rf = 0; n_rst = 0; n_px = 0;
    @(negedge clk);
    chk_valid = 1'b1; chk_paddr = pa; mem_limit = lim; cur_pc = pc;
    modes = px ? 16'h000C : 16'h0004;
    @(negedge clk);
    chk(busy == hit, "R10 busy after accept", {31'b0, busy}, {31'b0, hit});
    if (hit) begin
      // competing check while busy: must be ignored (R8)
      chk_paddr = 24'hFFFFFF; cur_pc = ~pc;
      repeat (3) @(negedge clk);
    end
    chk_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk(!busy, "R10 busy clear", {31'b0, busy}, 32'd0);
    if (!hit) begin
      chk(n_rf == 0 && n_acc == 0 && n_rst == 0 && n_px == 0, "R1 no action below limit",
          n_rf + n_acc + n_rst + n_px, 32'd0);
    end else begin
      chk(n_rf == 3, "R8 exactly three writes", n_rf, 32'd3);
      chk(log_a[0] == 6'o36 && log_d[0] == {16'h0, pc}, "R2 pc slot", {log_a[0], log_d[0][25:0]}, {6'o36, 10'h0, pc});
      chk(log_a[1] == 6'o35 && log_d[1] == 32'h0000D000, "R2 status slot", log_d[1], 32'hD000);
      chk(log_a[2] == 6'o34 && log_d[2] == {8'h0, pa}, "R2 address slot", log_d[2], {8'h0, pa});
      if (px) begin
        chk(n_px == 1 && n_rst == 0 && n_acc == 0, "R3 exchange path", {n_px[7:0], n_rst[7:0], n_acc[15:0]}, 32'h01000000);
      end else begin
        chk(n_acc == 2 && n_px == 0, "R4 two accesses", n_acc, 32'd2);
        chk(bmem[tgt] == pc, "R5 return stored", {16'h0, bmem[tgt]}, {16'h0, pc});
        chk(n_rst == 1, "R6 one restart", n_rst, 32'd1);
        chk(last_pc == tgt + 16'd1, "R6 new pc", {16'h0, last_pc}, {16'h0, 16'(tgt + 16'd1)});
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) bmem[i] = 16'h0;
    repeat (4) @(negedge clk);
    chk(!busy && !restart && !px_check && !rf_we && !mem_req, "R9 reset state",
        {27'b0, busy, restart, px_check, rf_we, mem_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req, "R9 idle after reset", {30'b0, busy, mem_req}, 32'd0);
    begin
      int n;
      n = 0;
      for (int li = 0; li < 3; li++) begin
        logic [23:0] lim;
        lim = (li == 0) ? 24'h000100 : (li == 1) ? 24'h7FFF00 : 24'hFFFFFF;
        for (int d = -2; d <= 2; d++) begin
          longint a;
          a = longint'(lim) + d;
          if (a < 0 || a > 24'hFFFFFF) continue;
          for (int p = 0; p < 2; p++) begin
            for (int l = 0; l < 3; l++) begin
              logic [15:0] tgt;
              lat = l;
              tgt = (n % 17 == 5) ? 16'hFFFF : 16'(16'h0200 + n); // R6 wrap case included
              run_case(24'(a), lim, 16'(16'h1000 + n * 37), p[0], tgt);
              n++;
            end
          end
        end
      end
    end
    // R7: long-latency access still completes
    lat = 2;
    run_case(24'h000200, 24'h000100, 16'hABCD, 1'b0, 16'h0FFF);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule